// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block runs the fixed memory sequence a processor core needs in order to enter and leave an interrupt service routine. It accepts three kinds of request: a level-sensitive maskable request, a non-maskable request that is caught on its rising edge, and a software request that carries an 8-bit type number. It also accepts a return command. When it accepts a request, it captures the core's current IP, CS, flags, SS and SP from its inputs. It pushes flags, CS and IP onto the stack, reads the new IP and CS from the vector table, and then presents the new program counter, the new flags and the new stack pointer for one cycle on `pc_load`. The return command pops the three words back and presents them in the same way.

A maskable request is acknowledged with a one-cycle `inta` pulse. The type number is then taken from `ack_type` in the cycle that follows. A non-maskable request always uses type 2. Memory is a single word port. A read issued in one cycle returns its data in the next cycle, and each word holds the byte at the even address in bits 7:0.

States: IDLE, ACK, TYPE, PUSH_FL, PUSH_CS, PUSH_IP, VEC_IP, VEC_CS, VEC_WAIT, POP_IP, POP_CS, POP_FL, POP_WAIT, DONE. Transitions:
- IDLE goes to PUSH_FL on a non-maskable or software request.
- IDLE goes to ACK on a maskable request.
- IDLE goes to POP_IP on a return command.
- The entry path runs ACK to TYPE to PUSH_FL.
- The push path runs PUSH_FL to PUSH_CS to PUSH_IP to VEC_IP to VEC_CS to VEC_WAIT to DONE.
- The return path runs POP_IP to POP_CS to POP_FL to POP_WAIT to DONE.
- DONE goes back to IDLE.

Top module: `vec_int_sequencer`

## Requirements
- R1: After reset, `busy`, `inta`, `pc_load`, `mem_rd` and `mem_wr` are low, and with no request the block makes no memory access.
- R2: A maskable request accepted while flag bit 9 (interrupt enable) is set gives exactly one `inta` pulse. The type is sampled from `ack_type` in the cycle after the pulse, and the entry holds `busy` for 8 cycles.
- R3: A maskable request is ignored while flag bit 9 is clear: there is no `inta`, no `busy` and no memory access.
- R4: A rising edge on `nmi` is latched and serviced with type 2 whatever the value of flag bit 9, and without `inta`.
- R5: When several requests are pending in the same cycle, the order of priority is non-maskable, then maskable, then software, then return.
- R6: A software request enters with the type on `soft_type` and without `inta`, and holds `busy` for 6 cycles.
- R7: An entry writes the flags, then CS, then IP. Each word goes to SS*16 + SP after SP has been decremented by 2, so the three addresses fall by 2 each time.
- R8: After the pushes, the block reads the word at type*4 and uses it as the new IP, then reads the word at type*4+2 and uses it as the new CS.
- R9: On entry, `new_flags` equals the saved flags with bit 9 and bit 8 (trap) cleared, and `new_sp` equals the old SP minus 6.
- R10: `busy` is high from the cycle after acceptance until `pc_load`. `pc_load` is a one-cycle pulse during which `busy` is low and the new values are valid.
- R11: A return command reads IP at SS*16+SP, then CS at +2, then flags at +4. It presents these values unchanged with `new_sp` equal to SP plus 6, and holds `busy` for 4 cycles.
- R12: Software, return and maskable requests that arrive while the block is busy are dropped. A non-maskable edge that arrives while busy is kept and serviced afterwards.
- R13: Every memory access is to an even address, and a read and a write never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| intr | input | 1 | Maskable request, level |
| nmi | input | 1 | Non-maskable request, rising edge |
| soft_req | input | 1 | Software interrupt command |
| soft_type | input | 8 | Type for software command |
| ret_req | input | 1 | Interrupt-return command |
| inta | output | 1 | Acknowledge pulse for maskable request |
| ack_type | input | 8 | Type supplied after acknowledge |
| cur_ip | input | 16 | Current instruction offset |
| cur_cs | input | 16 | Current code segment |
| cur_flags | input | 16 | Current flags |
| cur_ss | input | 16 | Current stack segment |
| cur_sp | input | 16 | Current stack pointer |
| mem_addr | output | 20 | Physical word address |
| mem_rd | output | 1 | Read strobe, data next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data |
| busy | output | 1 | Sequence in progress |
| pc_load | output | 1 | New state valid, one cycle |
| new_ip | output | 16 | New instruction offset |
| new_cs | output | 16 | New code segment |
| new_flags | output | 16 | New flags |
| new_sp | output | 16 | New stack pointer |

## Verification
Software entries are swept over all 256 type numbers, each with different saved IP, CS, flags and SP values. This shows that the vector address follows the type and that the pushed words carry the saved state rather than constants. Maskable entries with a spread of acknowledged types show that the type is sampled after `inta`. Masked requests, requests that arrive while busy, and simultaneous requests separate the masking, the dropping of requests and the priority order. Return commands that follow entries show that the stack image round-trips to the original state.

// File: rtl/vis_pkg.sv
package vis_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ACK,
        ST_TYPE,
        ST_PUSH_FL,
        ST_PUSH_CS,
        ST_PUSH_IP,
        ST_VEC_IP,
        ST_VEC_CS,
        ST_VEC_WAIT,
        ST_POP_IP,
        ST_POP_CS,
        ST_POP_FL,
        ST_POP_WAIT,
        ST_DONE
    } seq_state_e;

    typedef enum logic [2:0] {
        RQ_NONE,
        RQ_NMI,
        RQ_MASKABLE,
        RQ_SOFT,
        RQ_RETURN
    } req_kind_e;

    typedef enum logic [1:0] {
        WD_FLAGS,
        WD_SEG,
        WD_OFF
    } push_src_e;

endpackage

// File: rtl/vis_nmi_catch.sv
module vis_nmi_catch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi,
    input  logic take,
    output logic pend
);

    logic nmi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            nmi_q <= nmi;
            // a fresh edge wins over a same-cycle acceptance
            if (nmi && !nmi_q) begin
                pend <= 1'b1;
            end else if (take) begin
                pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/vis_arbiter.sv
module vis_arbiter
    import vis_pkg::*;
(
    input  logic      nmi_pend,
    input  logic      intr,
    input  logic      int_en,
    input  logic      soft_req,
    input  logic      ret_req,
    output req_kind_e kind
);

    always_comb begin
        if (nmi_pend) begin
            kind = RQ_NMI;
        end else if (intr && int_en) begin
            kind = RQ_MASKABLE;
        end else if (soft_req) begin
            kind = RQ_SOFT;
        end else if (ret_req) begin
            kind = RQ_RETURN;
        end else begin
            kind = RQ_NONE;
        end
    end

endmodule

// File: rtl/vis_addr_unit.sv
module vis_addr_unit #(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned SEG_SHIFT = 4,
    parameter int unsigned TYPE_W    = 8
) (
    input  logic                        sel_vec,
    input  logic [TYPE_W-1:0]           vtype,
    input  logic                        vhi,
    input  logic [DATA_W-1:0]           seg,
    input  logic [DATA_W-1:0]           off,
    output logic [DATA_W+SEG_SHIFT-1:0] addr
);

    localparam int unsigned AW  = DATA_W + SEG_SHIFT;
    localparam int unsigned PAD = AW - TYPE_W - 2;

    logic [AW-1:0] stk_addr;
    logic [AW-1:0] vec_addr;

    always_comb begin
        stk_addr = {seg, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, off};
        vec_addr = {{PAD{1'b0}}, vtype, vhi, 1'b0};
        addr     = sel_vec ? vec_addr : stk_addr;
    end

endmodule

// File: rtl/vec_int_sequencer.sv
module vec_int_sequencer
    import vis_pkg::*;
#(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned SEG_SHIFT  = 4,
    parameter int unsigned TYPE_W     = 8,
    parameter int unsigned IE_BIT     = 9,
    parameter int unsigned TRAP_BIT   = 8,
    parameter int unsigned NMI_VECTOR = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        intr,
    input  logic                        nmi,
    input  logic                        soft_req,
    input  logic [TYPE_W-1:0]           soft_type,
    input  logic                        ret_req,
    output logic                        inta,
    input  logic [TYPE_W-1:0]           ack_type,
    input  logic [DATA_W-1:0]           cur_ip,
    input  logic [DATA_W-1:0]           cur_cs,
    input  logic [DATA_W-1:0]           cur_flags,
    input  logic [DATA_W-1:0]           cur_ss,
    input  logic [DATA_W-1:0]           cur_sp,
    output logic [DATA_W+SEG_SHIFT-1:0] mem_addr,
    output logic                        mem_rd,
    output logic                        mem_wr,
    output logic [DATA_W-1:0]           mem_wdata,
    input  logic [DATA_W-1:0]           mem_rdata,
    output logic                        busy,
    output logic                        pc_load,
    output logic [DATA_W-1:0]           new_ip,
    output logic [DATA_W-1:0]           new_cs,
    output logic [DATA_W-1:0]           new_flags,
    output logic [DATA_W-1:0]           new_sp
);

    localparam logic [DATA_W-1:0] WSTEP      = DATA_W'(2);
    localparam logic [DATA_W-1:0] IE_MASK    = DATA_W'(1) << IE_BIT;
    localparam logic [DATA_W-1:0] TRAP_MASK  = DATA_W'(1) << TRAP_BIT;
    localparam logic [DATA_W-1:0] ENTRY_KEEP = ~(IE_MASK | TRAP_MASK);
    localparam logic [TYPE_W-1:0] NMI_TYPE   = TYPE_W'(NMI_VECTOR);

    seq_state_e state_q, state_d;
    req_kind_e  kind;

    logic              nmi_pend;
    logic              nmi_take;
    logic [TYPE_W-1:0] type_q;
    logic [DATA_W-1:0] ip_q, cs_q, fl_q, ss_q, sp_q;
    logic [DATA_W-1:0] nip_q, ncs_q, nfl_q;
    logic [DATA_W-1:0] sp_dec, sp_inc;

    logic              sel_vec, vhi, use_dec;
    push_src_e         wsrc;
    logic [DATA_W-1:0] stk_off;

    assign sp_dec   = sp_q - WSTEP;
    assign sp_inc   = sp_q + WSTEP;
    assign stk_off  = use_dec ? sp_dec : sp_q;
    assign nmi_take = (state_q == ST_IDLE) && (kind == RQ_NMI);

    vis_nmi_catch u_nmi (
        .clk   (clk),
        .rst_n (rst_n),
        .nmi   (nmi),
        .take  (nmi_take),
        .pend  (nmi_pend)
    );

    vis_arbiter u_arb (
        .nmi_pend (nmi_pend),
        .intr     (intr),
        .int_en   (cur_flags[IE_BIT]),
        .soft_req (soft_req),
        .ret_req  (ret_req),
        .kind     (kind)
    );

    vis_addr_unit #(
        .DATA_W    (DATA_W),
        .SEG_SHIFT (SEG_SHIFT),
        .TYPE_W    (TYPE_W)
    ) u_addr (
        .sel_vec (sel_vec),
        .vtype   (type_q),
        .vhi     (vhi),
        .seg     (ss_q),
        .off     (stk_off),
        .addr    (mem_addr)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                unique case (kind)
                    RQ_NMI, RQ_SOFT: state_d = ST_PUSH_FL;
                    RQ_MASKABLE:     state_d = ST_ACK;
                    RQ_RETURN:       state_d = ST_POP_IP;
                    default:         state_d = ST_IDLE;
                endcase
            end
            ST_ACK:      state_d = ST_TYPE;
            ST_TYPE:     state_d = ST_PUSH_FL;
            ST_PUSH_FL:  state_d = ST_PUSH_CS;
            ST_PUSH_CS:  state_d = ST_PUSH_IP;
            ST_PUSH_IP:  state_d = ST_VEC_IP;
            ST_VEC_IP:   state_d = ST_VEC_CS;
            ST_VEC_CS:   state_d = ST_VEC_WAIT;
            ST_VEC_WAIT: state_d = ST_DONE;
            ST_POP_IP:   state_d = ST_POP_CS;
            ST_POP_CS:   state_d = ST_POP_FL;
            ST_POP_FL:   state_d = ST_POP_WAIT;
            ST_POP_WAIT: state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        inta    = 1'b0;
        busy    = 1'b1;
        pc_load = 1'b0;
        mem_rd  = 1'b0;
        mem_wr  = 1'b0;
        sel_vec = 1'b0;
        vhi     = 1'b0;
        use_dec = 1'b0;
        wsrc    = WD_FLAGS;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_ACK:  inta = 1'b1;
            ST_TYPE: ;
            ST_PUSH_FL: begin
                mem_wr  = 1'b1;
                use_dec = 1'b1;
                wsrc    = WD_FLAGS;
            end
            ST_PUSH_CS: begin
                mem_wr  = 1'b1;
                use_dec = 1'b1;
                wsrc    = WD_SEG;
            end
            ST_PUSH_IP: begin
                mem_wr  = 1'b1;
                use_dec = 1'b1;
                wsrc    = WD_OFF;
            end
            ST_VEC_IP: begin
                mem_rd  = 1'b1;
                sel_vec = 1'b1;
            end
            ST_VEC_CS: begin
                mem_rd  = 1'b1;
                sel_vec = 1'b1;
                vhi     = 1'b1;
            end
            ST_VEC_WAIT: ;
            ST_POP_IP, ST_POP_CS, ST_POP_FL: mem_rd = 1'b1;
            ST_POP_WAIT: ;
            ST_DONE: begin
                busy    = 1'b0;
                pc_load = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    always_comb begin
        unique case (wsrc)
            WD_SEG:  mem_wdata = cs_q;
            WD_OFF:  mem_wdata = ip_q;
            default: mem_wdata = fl_q;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            type_q <= '0;
            ip_q   <= '0;
            cs_q   <= '0;
            fl_q   <= '0;
            ss_q   <= '0;
            sp_q   <= '0;
            nip_q  <= '0;
            ncs_q  <= '0;
            nfl_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (kind != RQ_NONE) begin
                        ip_q   <= cur_ip;
                        cs_q   <= cur_cs;
                        fl_q   <= cur_flags;
                        ss_q   <= cur_ss;
                        sp_q   <= cur_sp;
                        type_q <= (kind == RQ_NMI) ? NMI_TYPE : soft_type;
                    end
                end
                ST_TYPE:    type_q <= ack_type;
                ST_PUSH_FL, ST_PUSH_CS, ST_PUSH_IP: sp_q <= sp_dec;
                ST_VEC_CS:  nip_q <= mem_rdata;
                ST_VEC_WAIT: begin
                    ncs_q <= mem_rdata;
                    nfl_q <= fl_q & ENTRY_KEEP;
                end
                ST_POP_IP:  sp_q <= sp_inc;
                ST_POP_CS: begin
                    sp_q  <= sp_inc;
                    nip_q <= mem_rdata;
                end
                ST_POP_FL: begin
                    sp_q  <= sp_inc;
                    ncs_q <= mem_rdata;
                end
                ST_POP_WAIT: nfl_q <= mem_rdata;
                default: ;
            endcase
        end
    end

    assign new_ip    = nip_q;
    assign new_cs    = ncs_q;
    assign new_flags = nfl_q;
    assign new_sp    = sp_q;

endmodule

// File: rtl/vis_seq_chk.sv
module vis_seq_chk #(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned SEG_SHIFT = 4,
    parameter int unsigned TYPE_W    = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        inta,
    input logic                        busy,
    input logic                        pc_load,
    input logic                        mem_rd,
    input logic                        mem_wr,
    input logic [DATA_W+SEG_SHIFT-1:0] mem_addr
);

    localparam int unsigned AW = DATA_W + SEG_SHIFT;

    // R2
    inta_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inta |=> !inta);

    // R2
    inta_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inta |-> busy);

    // R13
    mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R13
    mem_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> !mem_addr[0]);

    // R7
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(mem_wr)) |-> (mem_addr == $past(mem_addr) - AW'(2)));

    // R8
    vec_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_wr)) |-> ((mem_addr >> (TYPE_W + 2)) == '0));

    // R10
    load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> !busy);

    // R10
    load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !pc_load);

    // R10
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> pc_load);

endmodule

bind vec_int_sequencer vis_seq_chk #(
    .DATA_W    (DATA_W),
    .SEG_SHIFT (SEG_SHIFT),
    .TYPE_W    (TYPE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .inta     (inta),
    .busy     (busy),
    .pc_load  (pc_load),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr)
);

// File: tb/vec_int_sequencer_tb.sv
module vec_int_sequencer_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        intr = 1'b0, nmi = 1'b0, soft_req = 1'b0, ret_req = 1'b0;
    logic [7:0]  soft_type = 8'h00, ack_type = 8'h00;
    logic [15:0] cur_ip = 16'h0, cur_cs = 16'h0, cur_flags = 16'h0;
    logic [15:0] cur_ss = 16'h0, cur_sp = 16'h0;
    logic        inta, mem_rd, mem_wr, busy, pc_load;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = 16'h0;
    logic [15:0] new_ip, new_cs, new_flags, new_sp;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_int_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .intr(intr), .nmi(nmi),
        .soft_req(soft_req), .soft_type(soft_type), .ret_req(ret_req),
        .inta(inta), .ack_type(ack_type),
        .cur_ip(cur_ip), .cur_cs(cur_cs), .cur_flags(cur_flags),
        .cur_ss(cur_ss), .cur_sp(cur_sp),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .pc_load(pc_load),
        .new_ip(new_ip), .new_cs(new_cs), .new_flags(new_flags), .new_sp(new_sp)
    );

    // byte-wide memory model, word port, low byte at even address
    logic [7:0]  bmem [logic [19:0]];
    logic [19:0] log_a [16];
    logic        log_w [16];
    logic [15:0] log_d [16];
    int          log_n = 0;

    function automatic logic [7:0] rbyte(input logic [19:0] a);
        return bmem.exists(a) ? bmem[a] : 8'h00;
    endfunction

    always @(posedge clk) begin
        if (mem_wr) begin
            bmem[mem_addr]         = mem_wdata[7:0];
            bmem[mem_addr + 20'd1] = mem_wdata[15:8];
        end
        if (mem_rd) mem_rdata <= {rbyte(mem_addr + 20'd1), rbyte(mem_addr)};
        if (mem_wr || mem_rd) begin
            log_a[log_n & 15] = mem_addr;
            log_w[log_n & 15] = mem_wr;
            log_d[log_n & 15] = mem_wdata;
            log_n = log_n + 1;
        end
    end

    function automatic logic [15:0] vip(input logic [7:0] t);
        return {t ^ 8'h5A, t};
    endfunction
    function automatic logic [15:0] vcs(input logic [7:0] t);
        return {~t, t ^ 8'h33};
    endfunction
    function automatic logic [19:0] phys(input logic [15:0] sg, input logic [15:0] off);
        return {sg, 4'h0} + {4'h0, off};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    task automatic wait_load(output int nb, output int ni);
        bit got;
        nb = 0; ni = 0; got = 0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            soft_req = 0; ret_req = 0; intr = 0; nmi = 0;
            if (pc_load) begin got = 1; break; end
            if (busy) nb++;
            if (inta) ni++;
        end
        chk(got, "R10", "pc_load reached", {31'd0, got}, 32'd1);
    endtask

    task automatic check_entry(input int s, input logic [7:0] t,
                               input logic [15:0] ip, input logic [15:0] cs,
                               input logic [15:0] fl, input logic [15:0] ss,
                               input logic [15:0] sp);
        logic [15:0] pv [3];
        bit ok;
        pv[0] = fl; pv[1] = cs; pv[2] = ip;
        chk(log_n - s == 5, "R13", "access count entry", log_n - s, 5);
        for (int k = 0; k < 3; k++) begin
            ok = log_w[(s+k)&15] && log_a[(s+k)&15] == phys(ss, sp - 16'(2*(k+1)))
                 && log_d[(s+k)&15] == pv[k];
            chk(ok, "R7", "push word", {log_a[(s+k)&15][15:0], log_d[(s+k)&15]},
                {phys(ss, sp - 16'(2*(k+1)))[15:0], pv[k]});
        end
        ok = !log_w[(s+3)&15] && log_a[(s+3)&15] == {10'd0, t, 2'b00}
             && !log_w[(s+4)&15] && log_a[(s+4)&15] == {10'd0, t, 2'b10};
        chk(ok, "R8", "vector addresses", {12'd0, log_a[(s+3)&15]}, {22'd0, t, 2'b00});
        chk(new_ip == vip(t) && new_cs == vcs(t), "R8", "new cs:ip",
            {new_cs, new_ip}, {vcs(t), vip(t)});
        chk(new_flags == (fl & 16'hFCFF), "R9", "entry flags", new_flags, fl & 16'hFCFF);
        chk(new_sp == sp - 16'd6, "R9", "entry sp", new_sp, sp - 16'd6);
    endtask

    task automatic check_return(input int s, input logic [15:0] ip, input logic [15:0] cs,
                                input logic [15:0] fl, input logic [15:0] ss,
                                input logic [15:0] sp);
        bit ok;
        ok = (log_n - s == 3);
        for (int k = 0; k < 3; k++)
            ok = ok && !log_w[(s+k)&15] && log_a[(s+k)&15] == phys(ss, sp + 16'(2*k));
        chk(ok, "R11", "pop addresses", {12'd0, log_a[s&15]}, {12'd0, phys(ss, sp)});
        chk(new_ip == ip && new_cs == cs && new_flags == fl, "R11", "restored state",
            {new_cs, new_ip}, {cs, ip});
        chk(new_flags == fl, "R11", "restored flags", new_flags, fl);
        chk(new_sp == sp + 16'd6, "R11", "return sp", new_sp, sp + 16'd6);
    endtask

    initial begin
        int nb, ni, s;
        logic [15:0] ip, cs, fl, sp;
        logic [7:0]  ty;
        for (int t = 0; t < 256; t++) begin
            bmem[20'(t*4)]     = vip(8'(t))[7:0];
            bmem[20'(t*4 + 1)] = vip(8'(t))[15:8];
            bmem[20'(t*4 + 2)] = vcs(8'(t))[7:0];
            bmem[20'(t*4 + 3)] = vcs(8'(t))[15:8];
        end
        cur_ss = 16'h2000;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !inta && !pc_load && !mem_rd && !mem_wr, "R1", "outputs in reset",
            {busy, inta, pc_load, mem_rd, mem_wr}, 0);
        rst_n = 1;
        s = log_n;
        repeat (6) begin
            @(negedge clk);
            chk(!busy && !inta && !pc_load, "R1", "idle after reset", {busy, inta, pc_load}, 0);
        end
        chk(log_n == s, "R1", "no access when idle", log_n - s, 0);

        // R6 R7 R8 R9 R10: software sweep over all types, R11 return every 32nd
        for (int t = 0; t < 256; t++) begin
            ip = 16'(t * 257) ^ 16'h1234;
            cs = 16'h4000 + 16'(t);
            fl = 16'h0300 | 16'(t) | ((t & 1) ? 16'h0800 : 16'h0000);
            sp = 16'h0200 + 16'(t * 2);
            cur_ip = ip; cur_cs = cs; cur_flags = fl; cur_sp = sp;
            s = log_n;
            soft_req = 1; soft_type = 8'(t);
            wait_load(nb, ni);
            chk(ni == 0, "R6", "no acknowledge for software", ni, 0);
            chk(nb == 6, "R10", "software busy cycles", nb, 6);
            check_entry(s, 8'(t), ip, cs, fl, 16'h2000, sp);
            @(negedge clk);
            if (t % 32 == 0) begin
                cur_sp = new_sp;
                s = log_n;
                ret_req = 1;
                wait_load(nb, ni);
                chk(nb == 4, "R11", "return busy cycles", nb, 4);
                check_return(s, ip, cs, fl, 16'h2000, sp - 16'd6);
                @(negedge clk);
            end
        end

        // R2: maskable requests with acknowledged types
        for (int k = 0; k < 16; k++) begin
            ty = 8'(k * 17 + 3);
            ip = 16'hA000 + 16'(k); cs = 16'h0F00 + 16'(k); fl = 16'h0200 | 16'(k);
            sp = 16'h0400;
            cur_ip = ip; cur_cs = cs; cur_flags = fl; cur_sp = sp;
            soft_type = ~ty;
            ack_type = ty;
            s = log_n;
            intr = 1;
            wait_load(nb, ni);
            chk(ni == 1, "R2", "one acknowledge pulse", ni, 1);
            chk(nb == 8, "R2", "maskable busy cycles", nb, 8);
            check_entry(s, ty, ip, cs, fl, 16'h2000, sp);
            @(negedge clk);
        end

        // R3: masked request ignored
        cur_flags = 16'h00C5;
        s = log_n;
        intr = 1;
        nb = 0; ni = 0;
        repeat (20) begin
            @(negedge clk);
            if (busy) nb++;
            if (inta) ni++;
        end
        intr = 0;
        chk(nb == 0 && ni == 0, "R3", "masked intr no busy or inta", {nb[15:0], ni[15:0]}, 0);
        chk(log_n == s, "R3", "masked intr no access", log_n - s, 0);

        // R4: nmi with enable clear
        cur_ip = 16'h7777; cur_cs = 16'h1111; cur_flags = 16'h0101; cur_sp = 16'h0800;
        s = log_n;
        nmi = 1;
        wait_load(nb, ni);
        chk(ni == 0, "R4", "nmi without acknowledge", ni, 0);
        check_entry(s, 8'd2, 16'h7777, 16'h1111, 16'h0101, 16'h2000, 16'h0800);
        @(negedge clk);

        // R5: nmi beats maskable and software
        cur_flags = 16'h0000; cur_sp = 16'h0900;
        ack_type = 8'h40; soft_type = 8'h41;
        intr = 1; nmi = 1;
        @(negedge clk);
        nmi = 0; cur_flags = 16'h0200; soft_req = 1; ret_req = 1;
        s = log_n;
        wait_load(nb, ni);
        chk(new_ip == vip(8'd2) && ni == 0, "R5", "nmi first", new_ip, vip(8'd2));
        @(negedge clk);
        // R5: maskable beats software
        s = log_n;
        intr = 1; soft_req = 1; ret_req = 1;
        wait_load(nb, ni);
        chk(new_ip == vip(8'h40) && ni == 1, "R5", "maskable over software", new_ip, vip(8'h40));
        @(negedge clk);
        // R5: software beats return
        s = log_n;
        soft_req = 1; ret_req = 1;
        wait_load(nb, ni);
        chk(new_ip == vip(8'h41) && log_w[s&15], "R5", "software over return", new_ip, vip(8'h41));
        @(negedge clk);

        // R12: requests while busy
        cur_flags = 16'h0000; cur_sp = 16'h0A00;
        soft_type = 8'h05; soft_req = 1;
        @(negedge clk);
        soft_req = 0;
        @(negedge clk);
        soft_type = 8'h09; soft_req = 1; ret_req = 1; nmi = 1;
        @(negedge clk);
        soft_req = 0; ret_req = 0; nmi = 0;
        wait_load(nb, ni);
        chk(new_ip == vip(8'h05), "R12", "first entry unaffected", new_ip, vip(8'h05));
        @(negedge clk);
        wait_load(nb, ni);
        chk(new_ip == vip(8'd2), "R12", "held nmi serviced", new_ip, vip(8'd2));
        @(negedge clk);
        s = log_n;
        nb = 0;
        repeat (8) begin
            @(negedge clk);
            if (busy || pc_load) nb++;
        end
        chk(nb == 0 && log_n == s, "R12", "dropped requests stay dropped", nb, 0);

        summary();
    end

endmodule